// File: doc/BRIEF.md
# Three-Operand Integer Execute Unit with Selective Flags

This unit performs the integer operations of a small load/store processor. The caller presents two operands, an operation code and a valid strobe. One clock edge later the unit shows a registered result and an updated flag register. The caller handles register reads, immediate sign extension and writeback. The unit only computes and records the outcome.

Relational operations do not set condition codes for a later branch. They produce a 0/1 value that the caller stores in a general register. Each class of operation writes only its own group of flags and leaves the others unchanged, so a later instruction can still read a flag set by an earlier one. The flag port packs zero, sign, carry and overflow from the most significant bit down.

Top module: `alu3op`

## Requirements
- R1: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B. Every defined code (0 to 14) shows its result on `result_o` at the first rising edge after it is presented with `valid_i` high.
- R2: Code 0 returns A+B and code 1 returns A-B, both modulo 2^WIDTH. Carry (`flags_o[1]`) becomes the carry out of the add, or the borrow of the subtract (A < B unsigned). Sign (`flags_o[2]`) and overflow (`flags_o[0]`) keep their previous values.
- R3: Code 2 returns the low WIDTH bits of the signed product. Overflow is set exactly when the signed product does not fit in WIDTH bits. Sign and carry keep their previous values.
- R4: Code 3 is signed division truncating toward zero. A zero divisor returns all ones with overflow set. The most negative value divided by -1 returns the most negative value with overflow set. Any other division clears overflow. Sign and carry keep their previous values.
- R5: Codes 7 to 12 are eq, ne, lt, le, gt and ge on signed operands. The result is exactly 1 for true and 0 for false.
- R6: Code 13 shifts A left and code 14 shifts A right logically (zero fill). The shift amount is the low log2(WIDTH) bits of B.
- R7: For every defined code, zero (`flags_o[3]`) is set exactly when the new result is zero. Codes 4 to 14 set sign to the result's top bit and keep carry and overflow.
- R8: When `valid_i` is low, or when the code is 15, `result_o` and `flags_o` keep their values.
- R9: While `rst_n` is low, `result_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code 0 to 15 |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand or shift amount |
| result_o | output | WIDTH | Registered result |
| flags_o | output | 4 | Registered flags {zero, sign, carry, overflow} |

## Verification
The result and all four flags are due at the first rising edge after the operation is presented. None is due earlier and none later. The bench drives each operation on a falling edge and reads both outputs on the next falling edge, after exactly one register stage. Its reference flag register is updated in the same step. Every comparison, including the flags an operation must leave alone, therefore checks the value the unit held over that cycle. Idle cycles and code 15 are checked on the same schedule and must show unchanged outputs.

// File: rtl/alu3op.sv
module alu3op #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o
);

  localparam int SHW = $clog2(WIDTH);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_DIV = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_EQ  = 4'd7;
  localparam logic [3:0] OP_NE  = 4'd8,  OP_LT  = 4'd9,  OP_LE  = 4'd10, OP_GT  = 4'd11;
  localparam logic [3:0] OP_GE  = 4'd12, OP_SHL = 4'd13, OP_SHR = 4'd14, OP_NONE = 4'd15;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH:0]         sum_w, dif_w;
  logic [2*WIDTH-1:0]     prod_w;
  logic [WIDTH-1:0]       hi_w;
  logic                   mul_ovf;
  logic                   div_zero, div_wrap;
  logic [WIDTH-1:0]       divisor, quot_w;
  logic                   is_eq, is_lt;
  logic [SHW-1:0]         sh_amt;
  logic [WIDTH-1:0]       res_n;
  logic [3:0]             flags_n;
  logic                   z_n;
  logic                   update;

  assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w  = {1'b0, a_i} - {1'b0, b_i};

  assign prod_w  = $signed(a_i) * $signed(b_i);
  assign hi_w    = prod_w[2*WIDTH-1:WIDTH];
  assign mul_ovf = (hi_w != {WIDTH{prod_w[WIDTH-1]}});

  assign div_zero = (b_i == '0);
  assign div_wrap = (a_i == MOST_NEG) && (&b_i);
  assign divisor  = (div_zero || div_wrap) ? ONE : b_i;
  assign quot_w   = $signed(a_i) / $signed(divisor);

  assign is_eq  = (a_i == b_i);
  assign is_lt  = ($signed(a_i) < $signed(b_i));
  assign sh_amt = b_i[SHW-1:0];

  always_comb begin
    res_n = '0;
    case (op_i)
      OP_ADD: res_n = sum_w[WIDTH-1:0];
      OP_SUB: res_n = dif_w[WIDTH-1:0];
      OP_MUL: res_n = prod_w[WIDTH-1:0];
      OP_DIV: res_n = div_zero ? '1 : quot_w;
      OP_AND: res_n = a_i & b_i;
      OP_OR:  res_n = a_i | b_i;
      OP_XOR: res_n = a_i ^ b_i;
      OP_EQ:  res_n = {{(WIDTH-1){1'b0}}, is_eq};
      OP_NE:  res_n = {{(WIDTH-1){1'b0}}, !is_eq};
      OP_LT:  res_n = {{(WIDTH-1){1'b0}}, is_lt};
      OP_LE:  res_n = {{(WIDTH-1){1'b0}}, is_lt || is_eq};
      OP_GT:  res_n = {{(WIDTH-1){1'b0}}, !(is_lt || is_eq)};
      OP_GE:  res_n = {{(WIDTH-1){1'b0}}, !is_lt};
      OP_SHL: res_n = a_i << sh_amt;
      OP_SHR: res_n = a_i >> sh_amt;
      default: res_n = result_o;
    endcase
  end

  assign z_n = (res_n == '0);

  always_comb begin
    flags_n = flags_o;
    case (op_i)
      OP_ADD:          flags_n = {z_n, flags_o[2], sum_w[WIDTH], flags_o[0]};
      OP_SUB:          flags_n = {z_n, flags_o[2], dif_w[WIDTH], flags_o[0]};
      OP_MUL:          flags_n = {z_n, flags_o[2:1], mul_ovf};
      OP_DIV:          flags_n = {z_n, flags_o[2:1], div_zero || div_wrap};
      OP_NONE:         flags_n = flags_o;
      default:         flags_n = {z_n, res_n[WIDTH-1], flags_o[1:0]};
    endcase
  end

  assign update = valid_i && (op_i != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (update) begin
      result_o <= res_n;
      flags_o  <= flags_n;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || op_i == OP_NONE) |=> ($stable(result_o) && $stable(flags_o))); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != OP_NONE) |=> (flags_o[3] == (result_o == '0))); // R7
  AST_ADDSUB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i <= OP_SUB) |=> ($stable(flags_o[2]) && $stable(flags_o[0]))); // R2
  AST_MULDIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == OP_MUL || op_i == OP_DIV)) |=> $stable(flags_o[2:1])); // R3
  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_DIV && b_i == '0) |=> ((&result_o) && flags_o[0])); // R4
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= OP_EQ && op_i <= OP_GE) |=> (result_o[WIDTH-1:1] == '0)); // R5
  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= OP_AND && op_i <= OP_SHR) |=> (flags_o[2] == result_o[WIDTH-1] && $stable(flags_o[1:0]))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (result_o == '0 && flags_o == '0)); // R9

endmodule

// File: tb/alu3op_tb.sv
`timescale 1ns/1ps
module alu3op_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] result_o;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] m_res = '0;
  logic [3:0]   m_flg = '0;

  always #5 clk = ~clk;

  alu3op #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o));

  function automatic string tag(input logic [3:0] op);
    if (op <= 1) return "R2";
    if (op == 2) return "R3";
    if (op == 3) return "R4";
    if (op <= 6) return "R1";
    if (op <= 12) return "R5";
    if (op <= 14) return "R6";
    return "R8";
  endfunction

  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    int sa, sb, p, q, s;
    logic [W-1:0] r;
    sa = $signed(a); sb = $signed(b); r = '0;
    case (op)
      0: begin s = int'(a) + int'(b); r = s[W-1:0]; m_flg[1] = (s > 255); end
      1: begin r = a - b; m_flg[1] = (a < b); end
      2: begin p = sa * sb; r = p[W-1:0]; m_flg[0] = (p > 127 || p < -128); end
      3: begin
        if (b == 0) begin r = '1; m_flg[0] = 1'b1; end
        else if (sa == -128 && sb == -1) begin r = 8'h80; m_flg[0] = 1'b1; end
        else begin q = sa / sb; r = q[W-1:0]; m_flg[0] = 1'b0; end
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = W'(sa == sb);
      8: r = W'(sa != sb);
      9: r = W'(sa < sb);
      10: r = W'(sa <= sb);
      11: r = W'(sa > sb);
      12: r = W'(sa >= sb);
      13: r = a << b[2:0];
      14: r = a >> b[2:0];
      default: r = m_res;
    endcase
    if (op != 15) begin
      m_res = r;
      m_flg[3] = (r == 0);
      if (op >= 4) m_flg[2] = r[W-1];
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input bit vld);
    valid_i = vld; op_i = op; a_i = a; b_i = b;
    if (vld) model(op, a, b);
    @(negedge clk);
    checks++;
    if (result_o !== m_res || flags_o !== m_flg) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h vld=%0d: result %h flags %b, expected %h %b",
               vld ? tag(op) : "R8", op, a, b, vld, result_o, flags_o, m_res, m_flg);
    end
    if (vld && op != 15) begin
      checks++;
      if (flags_o[3] !== (result_o == 0)) begin
        errors++;
        $display("FAIL R7 zero flag %b, expected %b", flags_o[3], result_o == 0);
      end
    end
  endtask

  logic [W-1:0] vals [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h7F, 8'h80, 8'h81,
                              8'hFE, 8'hFF, 8'h40, 8'hC0, 8'h10, 8'h55, 8'hAA, 8'h09};

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== '0 || flags_o !== '0) begin
      errors++;
      $display("FAIL R9 reset: result %h flags %b, expected 00 0000", result_o, flags_o);
    end
    rst_n = 1'b1;
    for (int op = 0; op < 15; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          apply(4'(op), vals[i], vals[j], 1'b1);
          if (j == 5) apply(4'(op), vals[j], vals[i], 1'b0);
          if (j == 9) apply(4'd15, vals[j], vals[i], 1'b1);
        end
    apply(4'd3, 8'h80, 8'hFF, 1'b1);
    apply(4'd3, 8'h05, 8'h00, 1'b1);
    apply(4'd0, 8'hFF, 8'h01, 1'b1);
    apply(4'd0, 8'h00, 8'h00, 1'b0);
    rst_n = 1'b0;
    m_res = '0; m_flg = '0;
    @(negedge clk);
    checks++;
    if (result_o !== '0 || flags_o !== '0) begin
      errors++;
      $display("FAIL R9 reset again: result %h flags %b, expected 00 0000", result_o, flags_o);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule